// File: doc/BRIEF.md
# BCD/Binary Calendar Clock Core

This block keeps the time of day and the calendar date in a small indexed register file: seconds, minutes, hours, day of week, day of month, month and a two-digit year. Next to these sit three alarm bytes for seconds, minutes and hours. A single-cycle pulse on `tick_1hz`, supplied by an external divider, advances the time by one second. Carries ripple through the fields up to the year. Month lengths are built in, and February is extended in years divisible by four.

Software reaches the registers in two steps. It first strobes an index into the block, and then either writes a byte at that index or reads the byte that the block presents on `rdata`. A control byte at index 11 selects the coding and the hour format, and holds a freeze bit:

- bit 2 selects plain binary (1) or BCD (0) coding of all time, date and alarm bytes;
- bit 1 selects the 24-hour format (1) or the 12-hour format (0). In 12-hour format, bit 7 of the hours byte is the PM flag;
- bit 7 freezes the once-per-second update while software loads a new time.

On every update, the new seconds, minutes and hours are compared with the alarm bytes. An alarm byte whose two top bits are both set matches any value of its field.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset, the register contents are as follows. Seconds (0), minutes (2) and hours (4) read 0. Day of week (6), day of month (7) and month (8) read 1. Year (9) reads 0. The alarm bytes (1, 3, 5) read 0. Control (11) reads 0x02. `rdata` shows the byte at the current index one clock after the index register takes a new value.
- R2: A data write stores `wdata` at the current index for indices 0 to 9 and 11. Indices 10, 12, 13, 14 and 15 ignore writes and always read 0x00.
- R3: Seconds count 0 to 59 and wrap to 0 with a carry into minutes. Minutes count 0 to 59 and wrap with a carry into hours. In 24-hour format, hours count 0 to 23 and wrap to 0 with a carry into the date.
- R4: In 12-hour format (control bit 1 = 0), the hours byte holds 1 to 12 in its low 7 bits and the PM flag in bit 7. The hour advances in this order: 11 AM to 12 PM, 12 PM to 1 PM, 11 PM to 12 AM (which carries into the date), and 12 AM to 1 AM. In BCD coding, 12 PM is 0x92 and 1 PM is 0x81.
- R5: With control bit 2 = 0, all fields are stored and counted in BCD, so seconds 0x09 are followed by 0x10. With bit 2 = 1, all fields count in plain binary, so seconds 0x09 are followed by 0x0A.
- R6: Day of week counts 1 to 7 and wraps to 1 when hours wrap. Day of month wraps to 1 after the last day of the month. Months 4, 6, 9 and 11 have 30 days, and February has 29 days when the year is divisible by 4 and 28 days otherwise. All other months have 31 days.
- R7: When the day of month wraps, the month advances. Month 12 wraps to 1 and increments the year, and year 99 wraps to 0.
- R8: While control bit 7 is 1, ticks change no time field and raise no alarm. Data writes are still accepted.
- R9: `alarm_hit` is high for exactly one clock, in the clock after a tick edge that performs an update. It rises only when the updated seconds, minutes and hours each equal their alarm byte bit for bit, or their alarm byte is 0xC0 or above.
- R10: A tick that arrives in the same clock as a data write is dropped. No field advances and `alarm_hit` stays low.
- R11: Without a tick, the time fields hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-clock pulse per second that requests an update |
| idx_we | input | 1 | Loads `wdata[3:0]` into the index register |
| dat_we | input | 1 | Writes `wdata` to the register at the current index |
| wdata | input | 8 | Host write data (index or register byte) |
| rdata | output | 8 | Registered byte at the current index |
| alarm_hit | output | 1 | One-clock pulse when an update matches the alarms |

## Verification
A wrong carry or wrap shows at the ports as a wrong field byte read back after the tick that crosses the boundary. A field that should stay unchanged shows it too. The error therefore appears two to three clocks after the tick, as soon as software reads that index. A wrong coding or hour format corrupts every later read of that field. It also corrupts the alarm comparison, so `alarm_hit` is missing or extra one clock after the tick. A freeze or collision fault appears as a seconds byte that moved when it should not have.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FLD_SEC  = 0;
  localparam int ALM_SEC  = 1;
  localparam int FLD_MIN  = 2;
  localparam int ALM_MIN  = 3;
  localparam int FLD_HR   = 4;
  localparam int ALM_HR   = 5;
  localparam int FLD_DOW  = 6;
  localparam int FLD_DOM  = 7;
  localparam int FLD_MON  = 8;
  localparam int FLD_YR   = 9;
  localparam int NUM_FLD  = 10;
  localparam int CTRL_IDX = 11;

  // Control byte bit positions
  localparam int CB_FREEZE = 7;
  localparam int CB_BIN    = 2;
  localparam int CB_H24    = 1;

  function automatic logic [7:0] to_bcd(input logic [7:0] v);
    logic [7:0] tens;
    logic [7:0] ones;
    tens = v / 8'd10;
    ones = v % 8'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [7:0] enc(input logic [7:0] v, input logic bin);
    return bin ? v : to_bcd(v);
  endfunction

  function automatic logic [7:0] dec(input logic [7:0] b, input logic bin);
    return bin ? b : ({4'b0, b[3:0]} + ({4'b0, b[7:4]} * 8'd10));
  endfunction
endpackage

// File: rtl/rtc_time_advance.sv
module rtc_time_advance (
  input  logic       bin_mode,
  input  logic       h24_mode,
  input  logic [7:0] sec_i,
  input  logic [7:0] min_i,
  input  logic [7:0] hr_i,
  input  logic [7:0] dow_i,
  input  logic [7:0] dom_i,
  input  logic [7:0] mon_i,
  input  logic [7:0] yr_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hr_o,
  output logic [7:0] dow_o,
  output logic [7:0] dom_o,
  output logic [7:0] mon_o,
  output logic [7:0] yr_o
);
  import rtc_pkg::*;

  logic [7:0] s, m, h, w, d, mo, y, h12;
  logic [7:0] s_n, m_n, h_n, w_n, d_n, mo_n, y_n;
  logic [7:0] mlen, h12_n, h_enc;
  logic       pm, pm_n, c_s, c_m, c_h, c_d, c_mo;

  always_comb begin
    s   = dec(sec_i, bin_mode);
    m   = dec(min_i, bin_mode);
    w   = dec(dow_i, bin_mode);
    d   = dec(dom_i, bin_mode);
    mo  = dec(mon_i, bin_mode);
    y   = dec(yr_i,  bin_mode);
    pm  = hr_i[7];
    h12 = dec({1'b0, hr_i[6:0]}, bin_mode);
    if (h24_mode) h = dec(hr_i, bin_mode);
    else if (h12 == 8'd12) h = pm ? 8'd12 : 8'd0;
    else h = pm ? (h12 + 8'd12) : h12;

    case (mo)
      8'd2:                    mlen = (y[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: mlen = 8'd30;
      default:                 mlen = 8'd31;
    endcase

    c_s  = (s >= 8'd59);
    s_n  = c_s ? 8'd0 : s + 8'd1;
    c_m  = c_s && (m >= 8'd59);
    m_n  = c_s ? ((m >= 8'd59) ? 8'd0 : m + 8'd1) : m;
    c_h  = c_m && (h >= 8'd23);
    h_n  = c_m ? ((h >= 8'd23) ? 8'd0 : h + 8'd1) : h;
    w_n  = c_h ? ((w >= 8'd7) ? 8'd1 : w + 8'd1) : w;
    c_d  = c_h && (d >= mlen);
    d_n  = c_h ? ((d >= mlen) ? 8'd1 : d + 8'd1) : d;
    c_mo = c_d && (mo >= 8'd12);
    mo_n = c_d ? ((mo >= 8'd12) ? 8'd1 : mo + 8'd1) : mo;
    y_n  = c_mo ? ((y >= 8'd99) ? 8'd0 : y + 8'd1) : y;

    pm_n = (h_n >= 8'd12);
    if (h_n == 8'd0 || h_n == 8'd12) h12_n = 8'd12;
    else if (h_n > 8'd12)            h12_n = h_n - 8'd12;
    else                             h12_n = h_n;
    h_enc = enc(h12_n, bin_mode);

    sec_o = enc(s_n, bin_mode);
    min_o = enc(m_n, bin_mode);
    hr_o  = h24_mode ? enc(h_n, bin_mode) : {pm_n, h_enc[6:0]};
    dow_o = enc(w_n, bin_mode);
    dom_o = enc(d_n, bin_mode);
    mon_o = enc(mo_n, bin_mode);
    yr_o  = enc(y_n, bin_mode);
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int NCMP = 3
) (
  input  logic [NCMP-1:0][7:0] cur,
  input  logic [NCMP-1:0][7:0] alm,
  output logic                 hit
);
  logic [NCMP-1:0] ok;

  for (genvar g = 0; g < NCMP; g++) begin : g_fld
    assign ok[g] = (alm[g][7:6] == 2'b11) || (alm[g] == cur[g]);
  end

  assign hit = &ok;
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core #(
  parameter int IDX_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_1hz,
  input  logic       idx_we,
  input  logic       dat_we,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       alarm_hit
);
  import rtc_pkg::*;

  localparam logic [IDX_W-1:0] I_NFLD = IDX_W'(NUM_FLD);
  localparam logic [IDX_W-1:0] I_CTRL = IDX_W'(CTRL_IDX);

  logic [7:0]       fld_q [0:NUM_FLD-1];
  logic [7:0]       ctrl_q;
  logic [IDX_W-1:0] idx_q;
  logic             upd;
  logic             match;
  logic [7:0]       n_sec, n_min, n_hr, n_dow, n_dom, n_mon, n_yr;

  assign upd = tick_1hz && !ctrl_q[CB_FREEZE] && !dat_we;

  rtc_time_advance u_adv (
    .bin_mode (ctrl_q[CB_BIN]),
    .h24_mode (ctrl_q[CB_H24]),
    .sec_i    (fld_q[FLD_SEC]),
    .min_i    (fld_q[FLD_MIN]),
    .hr_i     (fld_q[FLD_HR]),
    .dow_i    (fld_q[FLD_DOW]),
    .dom_i    (fld_q[FLD_DOM]),
    .mon_i    (fld_q[FLD_MON]),
    .yr_i     (fld_q[FLD_YR]),
    .sec_o    (n_sec),
    .min_o    (n_min),
    .hr_o     (n_hr),
    .dow_o    (n_dow),
    .dom_o    (n_dom),
    .mon_o    (n_mon),
    .yr_o     (n_yr)
  );

  rtc_alarm_cmp #(.NCMP(3)) u_alm (
    .cur ({n_hr, n_min, n_sec}),
    .alm ({fld_q[ALM_HR], fld_q[ALM_MIN], fld_q[ALM_SEC]}),
    .hit (match)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_FLD; k++) fld_q[k] <= 8'h00;
      fld_q[FLD_DOW] <= 8'h01;
      fld_q[FLD_DOM] <= 8'h01;
      fld_q[FLD_MON] <= 8'h01;
      ctrl_q    <= 8'h02;
      idx_q     <= '0;
      alarm_hit <= 1'b0;
    end else begin
      if (idx_we) idx_q <= wdata[IDX_W-1:0];
      if (dat_we) begin
        if (idx_q < I_NFLD)       fld_q[idx_q] <= wdata;
        else if (idx_q == I_CTRL) ctrl_q <= wdata;
      end else if (upd) begin
        fld_q[FLD_SEC] <= n_sec;
        fld_q[FLD_MIN] <= n_min;
        fld_q[FLD_HR]  <= n_hr;
        fld_q[FLD_DOW] <= n_dow;
        fld_q[FLD_DOM] <= n_dom;
        fld_q[FLD_MON] <= n_mon;
        fld_q[FLD_YR]  <= n_yr;
      end
      alarm_hit <= upd && match;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  rdata <= 8'h00;
    else if (idx_q < I_NFLD)  rdata <= fld_q[idx_q];
    else if (idx_q == I_CTRL) rdata <= ctrl_q;
    else                      rdata <= 8'h00;
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_1hz,
  input logic             dat_we,
  input logic             alarm_hit,
  input logic [7:0]       rdata,
  input logic [IDX_W-1:0] idx_q,
  input logic [7:0]       ctrl_q,
  input logic [7:0]       sec_q,
  input logic [7:0]       min_q
);
  assert_alarm_after_tick_R9: assert property (@(posedge clk) disable iff (rst)
    alarm_hit |-> ($past(tick_1hz) && !$past(ctrl_q[7]) && !$past(dat_we)));

  assert_freeze_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctrl_q[7]) && !$past(dat_we)) |-> $stable(sec_q));

  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tick_1hz) && !$past(dat_we)) |-> ($stable(sec_q) && $stable(min_q)));

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(idx_q) >= IDX_W'(12) || $past(idx_q) == IDX_W'(10)))
      |-> (rdata == 8'h00));

  assert_collision_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tick_1hz) && $past(dat_we)) |-> !alarm_hit);
endmodule

bind rtc_calendar_core rtc_calendar_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_1hz  (tick_1hz),
  .dat_we    (dat_we),
  .alarm_hit (alarm_hit),
  .rdata     (rdata),
  .idx_q     (idx_q),
  .ctrl_q    (ctrl_q),
  .sec_q     (fld_q[0]),
  .min_q     (fld_q[2])
);

// File: tb/sim_rtc_calendar_core.sv
`timescale 1ns/1ps
module sim_rtc_calendar_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_1hz = 1'b0;
  logic       idx_we = 1'b0;
  logic       dat_we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       alarm_hit;

  always #2.5 clk = ~clk;

  rtc_calendar_core u0 (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .idx_we(idx_we),
    .dat_we(dat_we), .wdata(wdata), .rdata(rdata), .alarm_hit(alarm_hit)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int ms, mm, mh, mw, md, mo, my;
  int as_, am, ah;
  bit bm, h24;

  function automatic int benc(int v, bit b);
    return b ? v : (((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int hbyte(int h, bit b, bit t);
    int h12;
    if (t) return benc(h, b);
    h12 = h % 12;
    if (h12 == 0) h12 = 12;
    return ((h >= 12) ? 128 : 0) | benc(h12, b);
  endfunction

  function automatic int mlen(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic madv();
    ms++;
    if (ms > 59) begin
      ms = 0; mm++;
      if (mm > 59) begin
        mm = 0; mh++;
        if (mh > 23) begin
          mh = 0;
          mw = (mw == 7) ? 1 : mw + 1;
          md++;
          if (md > mlen(mo, my)) begin
            md = 1; mo++;
            if (mo > 12) begin
              mo = 1;
              my = (my == 99) ? 0 : my + 1;
            end
          end
        end
      end
    end
  endtask

  function automatic int mhit();
    bit a, b, c;
    a = (as_ >= 192) || (as_ == benc(ms, bm));
    b = (am >= 192) || (am == benc(mm, bm));
    c = (ah >= 192) || (ah == hbyte(mh, bm, h24));
    return (a && b && c) ? 1 : 0;
  endfunction

  task automatic check(string tag, int got, int exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr_idx(int i);
    @(negedge clk); wdata = 8'(i); idx_we = 1'b1;
    @(negedge clk); idx_we = 1'b0;
  endtask

  task automatic wr_reg(int i, int v);
    wr_idx(i);
    wdata = 8'(v); dat_we = 1'b1;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic rd_reg(int i, output int v);
    wr_idx(i);
    @(negedge clk);
    v = int'(rdata);
  endtask

  task automatic chk_reg(string tag, int i, int exp);
    int v;
    rd_reg(i, v);
    check(tag, v, exp);
  endtask

  task automatic check_all(string tag);
    chk_reg({tag, " sec"}, 0, benc(ms, bm));
    chk_reg({tag, " min"}, 2, benc(mm, bm));
    chk_reg({tag, " hour"}, 4, hbyte(mh, bm, h24));
    chk_reg({tag, " dow"}, 6, benc(mw, bm));
    chk_reg({tag, " dom"}, 7, benc(md, bm));
    chk_reg({tag, " mon"}, 8, benc(mo, bm));
    chk_reg({tag, " year"}, 9, benc(my, bm));
  endtask

  task automatic set_time(int s, int m, int h, int w, int d, int mon, int y);
    ms = s; mm = m; mh = h; mw = w; md = d; mo = mon; my = y;
  endtask

  task automatic load();
    int cb;
    cb = (int'(bm) << 2) | (int'(h24) << 1);
    wr_reg(11, 128 | cb);
    wr_reg(0, benc(ms, bm));
    wr_reg(2, benc(mm, bm));
    wr_reg(4, hbyte(mh, bm, h24));
    wr_reg(6, benc(mw, bm));
    wr_reg(7, benc(md, bm));
    wr_reg(8, benc(mo, bm));
    wr_reg(9, benc(my, bm));
    wr_reg(1, as_);
    wr_reg(3, am);
    wr_reg(5, ah);
    wr_reg(11, cb);
  endtask

  task automatic raw_tick(output int hit);
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    hit = int'(alarm_hit);
  endtask

  task automatic tick_chk(string tag);
    int hit;
    raw_tick(hit);
    madv();
    check({tag, " alarm"}, hit, mhit());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog got hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int hit, v;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk_reg("R1 sec", 0, 8'h00);
    chk_reg("R1 hour", 4, 8'h00);
    chk_reg("R1 dow", 6, 8'h01);
    chk_reg("R1 dom", 7, 8'h01);
    chk_reg("R1 mon", 8, 8'h01);
    chk_reg("R1 alarm", 5, 8'h00);
    chk_reg("R1 ctrl", 11, 8'h02);

    // R2 unmapped indices and plain writes
    wr_reg(12, 8'h55);
    chk_reg("R2 idx12", 12, 8'h00);
    wr_reg(10, 8'hAA);
    chk_reg("R2 idx10", 10, 8'h00);
    chk_reg("R2 idx15", 15, 8'h00);
    wr_reg(1, 8'h37);
    chk_reg("R2 store", 1, 8'h37);

    // R3 R6 R7 full rollover, BCD 24h
    bm = 0; h24 = 1; as_ = 8'hC0; am = 8'hC0; ah = 8'hC0;
    set_time(59, 59, 23, 7, 31, 12, 99);
    load();
    tick_chk("R9 wildcard");
    check_all("R3 R6 R7 new year");
    chk_reg("R7 year wrap", 9, 8'h00);

    // R6 leap and non-leap February
    as_ = 8'h00; am = 8'h00; ah = 8'h00;
    set_time(59, 59, 23, 3, 28, 2, 24);
    load();
    tick_chk("R6 leap");
    chk_reg("R6 feb29", 7, 8'h29);
    set_time(59, 59, 23, 3, 28, 2, 23);
    load();
    tick_chk("R6 nonleap");
    chk_reg("R6 mar", 8, 8'h03);
    chk_reg("R6 mar1", 7, 8'h01);
    set_time(59, 59, 23, 3, 30, 4, 23);
    load();
    tick_chk("R6 30day");
    chk_reg("R6 may", 8, 8'h05);

    // R5 BCD versus binary digit carry
    set_time(9, 0, 0, 1, 1, 1, 0);
    load();
    tick_chk("R5 bcd");
    chk_reg("R5 bcd sec", 0, 8'h10);
    bm = 1;
    set_time(9, 0, 0, 1, 1, 1, 0);
    load();
    tick_chk("R5 bin");
    chk_reg("R5 bin sec", 0, 8'h0A);
    set_time(59, 59, 23, 7, 31, 12, 99);
    load();
    tick_chk("R5 bin wrap");
    check_all("R5 bin wrap");

    // R4 12-hour sequence, BCD
    bm = 0; h24 = 0;
    set_time(59, 59, 11, 2, 5, 6, 10);
    load();
    tick_chk("R4 noon");
    chk_reg("R4 12pm", 4, 8'h92);
    set_time(59, 59, 12, 2, 5, 6, 10);
    load();
    tick_chk("R4 1pm");
    chk_reg("R4 1pm", 4, 8'h81);
    set_time(59, 59, 23, 2, 5, 6, 10);
    load();
    tick_chk("R4 midnight");
    chk_reg("R4 12am", 4, 8'h12);
    check_all("R4 midnight");
    set_time(59, 59, 0, 2, 5, 6, 10);
    load();
    tick_chk("R4 1am");
    chk_reg("R4 1am", 4, 8'h01);

    // R9 exact alarm then miss
    h24 = 1;
    as_ = 8'h10; am = 8'h00; ah = 8'h00;
    set_time(9, 0, 0, 1, 1, 1, 0);
    load();
    raw_tick(hit);
    check("R9 exact hit", hit, 1);
    madv();
    raw_tick(hit);
    check("R9 single pulse", hit, 0);
    madv();

    // R11 no change without a tick
    repeat (20) @(negedge clk);
    chk_reg("R11 hold", 0, benc(ms, bm));

    // R8 freeze
    as_ = 8'hC0; am = 8'hC0; ah = 8'hC0;
    wr_reg(1, as_); wr_reg(3, am); wr_reg(5, ah);
    wr_reg(11, 8'h82);
    raw_tick(hit);
    check("R8 no alarm", hit, 0);
    chk_reg("R8 frozen", 0, benc(ms, bm));
    wr_reg(0, 8'h45);
    chk_reg("R8 write ok", 0, 8'h45);
    ms = 45;
    wr_reg(11, 8'h02);

    // R10 tick colliding with data write
    wr_idx(1);
    wdata = 8'hC3; dat_we = 1'b1; tick_1hz = 1'b1;
    @(negedge clk);
    dat_we = 1'b0; tick_1hz = 1'b0;
    check("R10 no alarm", int'(alarm_hit), 0);
    chk_reg("R10 sec held", 0, 8'h45);
    chk_reg("R10 write done", 1, 8'hC3);
    as_ = 8'hC3;

    // Random mix of modes, times and alarms
    for (int it = 0; it < 30; it++) begin
      int nt;
      bm  = 1'($urandom % 2);
      h24 = 1'($urandom % 2);
      my = $urandom % 100;
      mo = 1 + $urandom % 12;
      md = 1 + $urandom % mlen(mo, my);
      mw = 1 + $urandom % 7;
      mh = $urandom % 24;
      mm = ($urandom % 2 == 1) ? 59 : $urandom % 60;
      ms = ($urandom % 2 == 1) ? 59 - $urandom % 3 : $urandom % 60;
      if ($urandom % 4 == 0) begin mh = 23; md = mlen(mo, my); end
      as_ = ($urandom % 3 == 0) ? (8'hC0 | ($urandom % 64))
                                : benc((ms + 1 + $urandom % 2) % 60, bm);
      am = ($urandom % 2 == 1) ? 8'hFF : benc(mm, bm);
      ah = ($urandom % 2 == 1) ? 8'hC5 : hbyte(mh, bm, h24);
      load();
      nt = 1 + $urandom % 4;
      for (int t = 0; t < nt; t++) tick_chk("R9 random");
      check_all("R3 R4 R5 R6 random");
    end

    rd_reg(11, v);
    check("R2 ctrl readback", v, (int'(bm) << 2) | (int'(h24) << 1));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule